// File: doc/BRIEF.md
# Quadrature Decoder with Time Stamp

This block turns the two phase-shifted square waves of an incremental encoder (channel A and channel B, a quarter period apart) into a 16-bit position count. The count runs freely and wraps. Each raw input is first brought into the clock domain by a synchronizer. It then passes a short stability filter, and only then is it decoded. Every time the count moves, the block latches the value of an internal free-running timebase next to the new position. Software can use that time stamp to interpolate between counts, and to estimate velocity at low speed or with coarse encoders.

A select pin switches to a high-speed mode. In that mode channel B edges no longer move the count. Only the two edges of channel A are counted, each worth two positions, which halves the edge rate the decoder has to follow. An encoder index channel is not handled here.

The output side is a one-cycle update strobe, not a valid/ready stream. An encoder cannot be stalled, so the block has no back-pressure. Each result holds on the outputs until the next update, and a consumer that needs every event must sample on every strobe.

Top module: `qdec_stamp`

## Requirements
- R1: After reset, position, time stamp, direction, update strobe and error flag are all zero.
- R2: In normal mode every accepted single-channel change moves the position by one. With the state written as {A,B}, the order 00, 10, 11, 01, 00 counts up and the opposite order counts down. Direction reads 1 after an up count and 0 after a down count.
- R3: The position is 16 bits and wraps: one down count from 0 gives 16'hFFFF, and one up count from 16'hFFFF gives 0.
- R4: The timebase is 0 in the first clock after reset and adds one every clock. The update strobe is high for exactly one clock per position change, and alongside it the time stamp equals the timebase value of the clock in which the change was decoded. The time stamp holds between strobes.
- R5: An input level is accepted only once it has been stable for 2 consecutive clocks after synchronization. A 1-clock pulse on either input causes no strobe and no position change, and a 2-clock pulse is accepted.
- R6: In normal mode, if both accepted inputs change in the same clock, the position does not change and no strobe is given. The error flag is set and stays set until reset.
- R7: In high-speed mode, changes of B alone cause no strobe and no position change, and the error flag is never set. Each accepted change of A moves the position by two: up when the new A differs from the current B, down otherwise.
- R8: An input change held steady that is driven just before clock edge k produces its update strobe in the clock after edge k+4, with a time stamp equal to the timebase value k+3 cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Raw encoder channel A |
| enc_b | input | 1 | Raw encoder channel B |
| fast_mode | input | 1 | 1 selects high-speed (A-only, step 2) counting |
| pos | output | 16 | Position count |
| dir | output | 1 | Direction of the last count change, 1 = up |
| stamp | output | 16 | Timebase value captured at the last count change |
| upd | output | 1 | One-clock strobe per count change |
| err | output | 1 | Sticky flag for a both-channel change in normal mode |

## Verification
The bench walks every pair of source and destination input states in both modes, and computes the expected step from the Gray index difference. A decoder with A and B swapped, or with a wrong direction rule, would count the wrong way on half of these pairs. A decoder that still counts B in high-speed mode would move on B-only changes. The bench drives 1-clock and 2-clock glitches to catch a filter that is too short or too long. It steps down from zero and back to catch a count that saturates instead of wrapping. On every strobe it compares the time stamp with its own cycle count, so a stamp taken one clock late or a strobe that fires at the wrong time shows up at once.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;
endpackage

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl
);
  localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   synced;
  logic [CW-1:0]          run;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], raw};
  end

  assign synced = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0;
      lvl <= 1'b0;
    end else if (synced == lvl) begin
      run <= '0;
    end else if (run == CW'(FILT_CYC - 1)) begin
      run <= '0;
      lvl <= synced;
    end else begin
      run <= run + 1'b1;
    end
  end

  AST_FILT_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> ($past(synced) == lvl)); // R5
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a,
  input  logic       b,
  input  logic       fast,
  output step_e      step,
  output logic [1:0] mag
);
  logic a_p, b_p;
  logic ea, eb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_p <= 1'b0;
      b_p <= 1'b0;
    end else begin
      a_p <= a;
      b_p <= b;
    end
  end

  assign ea = a ^ a_p;
  assign eb = b ^ b_p;

  always_comb begin
    step = STEP_NONE;
    mag  = fast ? 2'd2 : 2'd1;
    if (fast) begin
      if (ea) step = (a != b) ? STEP_UP : STEP_DOWN;
    end else if (ea && eb) begin
      step = STEP_BAD;
    end else if (ea) begin
      step = (a != b) ? STEP_UP : STEP_DOWN;
    end else if (eb) begin
      step = (a == b) ? STEP_UP : STEP_DOWN;
    end
  end
endmodule

// File: rtl/qdec_track.sv
module qdec_track
  import qdec_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int TB_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  input  logic [1:0]       mag,
  output logic [POS_W-1:0] pos,
  output logic             dir,
  output logic [TB_W-1:0]  stamp,
  output logic             upd,
  output logic             err
);
  logic [TB_W-1:0] tbase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tbase <= '0;
      pos   <= '0;
      dir   <= 1'b0;
      stamp <= '0;
      upd   <= 1'b0;
      err   <= 1'b0;
    end else begin
      tbase <= tbase + 1'b1;
      upd   <= 1'b0;
      case (step)
        STEP_UP: begin
          pos   <= pos + POS_W'(mag);
          dir   <= 1'b1;
          stamp <= tbase;
          upd   <= 1'b1;
        end
        STEP_DOWN: begin
          pos   <= pos - POS_W'(mag);
          dir   <= 1'b0;
          stamp <= tbase;
          upd   <= 1'b1;
        end
        STEP_BAD: err <= 1'b1;
        default: ;
      endcase
    end
  end

  AST_POS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> (pos == $past(pos))); // R2
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ((dir ? POS_W'(pos - $past(pos)) : POS_W'($past(pos) - pos)) inside {POS_W'(1), POS_W'(2)})); // R2
  AST_STAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(stamp)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R6
  AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !upd); // R6
endmodule

// File: rtl/qdec_stamp.sv
module qdec_stamp
  import qdec_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             fast_mode,
  output logic [POS_W-1:0] pos,
  output logic             dir,
  output logic [TB_W-1:0]  stamp,
  output logic             upd,
  output logic             err
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_in;
  logic [NCH-1:0] clean;
  step_e          step;
  logic [1:0]     mag;

  assign raw_in = {enc_a, enc_b};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    qdec_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_in[i]),
      .lvl  (clean[i])
    );
  end

  qdec_decode u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .a    (clean[1]),
    .b    (clean[0]),
    .fast (fast_mode),
    .step (step),
    .mag  (mag)
  );

  qdec_track #(
    .POS_W(POS_W),
    .TB_W (TB_W)
  ) u_trk (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step),
    .mag  (mag),
    .pos  (pos),
    .dir  (dir),
    .stamp(stamp),
    .upd  (upd),
    .err  (err)
  );

  AST_FAST_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && $past(fast_mode)) |-> (POS_W'(pos - $past(pos)) inside {POS_W'(2), {POS_W{1'b1}} - POS_W'(1)})); // R7
  AST_FAST_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fast_mode) && !$past(err)) |-> !err); // R7
endmodule

// File: tb/tb_qdec_stamp.sv
module tb_qdec_stamp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0;
  logic        enc_b = 1'b0;
  logic        fast_mode = 1'b0;
  logic [15:0] pos;
  logic        dir;
  logic [15:0] stamp;
  logic        upd;
  logic        err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int upd_cnt = 0;
  int last_upd_cyc = 0;

  logic [15:0] exp_pos;
  logic        exp_dir;
  logic        exp_err;
  logic        cur_a, cur_b;

  qdec_stamp dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .fast_mode(fast_mode), .pos(pos), .dir(dir), .stamp(stamp),
    .upd(upd), .err(err)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // R4: every strobe carries the timebase of the decoding clock
  always @(negedge clk) begin
    if (rst_n && upd) begin
      upd_cnt++;
      last_upd_cyc = cyc;
      chk(stamp == 16'(cyc - 1), "R4", "stamp at strobe", stamp, (cyc - 1) & 16'hFFFF);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int gidx(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    enc_a = 1'b0;
    enc_b = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    exp_pos = '0;
    exp_dir = 1'b0;
    exp_err = 1'b0;
    cur_a = 1'b0;
    cur_b = 1'b0;
    @(negedge clk);
    chk(pos == 16'd0, "R1", "pos after reset", pos, 0);
    chk(stamp == 16'd0, "R1", "stamp after reset", stamp, 0);
    chk(dir == 1'b0, "R1", "dir after reset", dir, 0);
    chk(upd == 1'b0, "R1", "upd after reset", upd, 0);
    chk(err == 1'b0, "R1", "err after reset", err, 0);
  endtask

  task automatic move(input logic na, input logic nb, input string req);
    int d;
    int n0;
    int c0;
    int exp_n;
    d = (gidx(na, nb) - gidx(cur_a, cur_b) + 4) % 4;
    exp_n = 0;
    if (!fast_mode) begin
      if (d == 1)      begin exp_pos = exp_pos + 16'd1; exp_dir = 1'b1; exp_n = 1; end
      else if (d == 3) begin exp_pos = exp_pos - 16'd1; exp_dir = 1'b0; exp_n = 1; end
      else if (d == 2) exp_err = 1'b1;
    end else if (na != cur_a) begin
      exp_n = 1;
      if (na != nb) begin exp_pos = exp_pos + 16'd2; exp_dir = 1'b1; end
      else          begin exp_pos = exp_pos - 16'd2; exp_dir = 1'b0; end
    end
    @(negedge clk);
    enc_a = na;
    enc_b = nb;
    c0 = cyc;
    n0 = upd_cnt;
    cur_a = na;
    cur_b = nb;
    repeat (9) @(negedge clk);
    chk(pos == exp_pos, req, "pos", pos, exp_pos);
    chk(upd_cnt - n0 == exp_n, req, "strobe count", upd_cnt - n0, exp_n);
    chk(dir == exp_dir, req, "dir", dir, exp_dir);
    chk(err == exp_err, "R6", "err flag", err, exp_err);
    if (exp_n == 1)
      chk(last_upd_cyc == c0 + 5, "R8", "strobe latency", last_upd_cyc - c0, 5);
  endtask

  task automatic glitch(input bit on_a, input int len, input string req);
    int n0;
    logic [15:0] p0;
    @(negedge clk);
    n0 = upd_cnt;
    p0 = pos;
    if (on_a) enc_a = ~cur_a; else enc_b = ~cur_b;
    repeat (len) @(negedge clk);
    enc_a = cur_a;
    enc_b = cur_b;
    repeat (10) @(negedge clk);
    chk(pos == p0, req, "pos after pulse", pos, p0);
    chk(upd_cnt - n0 == ((len >= 2) ? 2 : 0), req, "strobes for pulse",
        upd_cnt - n0, (len >= 2) ? 2 : 0);
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < 4; t++) begin
        for (int k = 0; k < 4; k++) begin
          if (gidx(cur_a, cur_b) != s) begin
            case ((gidx(cur_a, cur_b) + 1) % 4)
              0: move(1'b0, 1'b0, req);
              1: move(1'b1, 1'b0, req);
              2: move(1'b1, 1'b1, req);
              default: move(1'b0, 1'b1, req);
            endcase
          end
        end
        case (t)
          0: move(1'b0, 1'b0, req);
          1: move(1'b1, 1'b0, req);
          2: move(1'b1, 1'b1, req);
          default: move(1'b0, 1'b1, req);
        endcase
      end
    end
  endtask

  initial begin
    do_reset();
    // R3: wrap down from zero and back up
    move(1'b0, 1'b1, "R3");
    chk(pos == 16'hFFFF, "R3", "wrap down", pos, 16'hFFFF);
    move(1'b0, 1'b0, "R3");
    chk(pos == 16'h0000, "R3", "wrap up", pos, 0);
    // R2: full forward and reverse cycles
    move(1'b1, 1'b0, "R2");
    move(1'b1, 1'b1, "R2");
    move(1'b0, 1'b1, "R2");
    move(1'b0, 1'b0, "R2");
    move(1'b0, 1'b1, "R2");
    move(1'b0, 1'b0, "R2");
    // R5: short pulses rejected, 2-clock pulses accepted
    glitch(1'b1, 1, "R5");
    glitch(1'b0, 1, "R5");
    glitch(1'b1, 2, "R5");
    glitch(1'b0, 2, "R5");
    // R2 and R6: all state pairs in normal mode
    sweep("R2");
    // R7: all state pairs in high-speed mode after a fresh reset
    do_reset();
    @(negedge clk);
    fast_mode = 1'b1;
    sweep("R7");
    move(1'b0, 1'b0, "R7");
    move(1'b1, 1'b1, "R7");
    @(negedge clk);
    fast_mode = 1'b0;
    do_reset();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule